// File: doc/BRIEF.md
# UART Host Register and FIFO Interface

This block is the processor-facing side of one asynchronous serial channel. A host reaches it over an 8-bit parallel bus: a 3-bit register index, an active-low chip select and active-low read and write strobes. Behind the bus sit a transmit FIFO and a receive FIFO, each 16 bytes deep. There are also registers for interrupt enable, FIFO control, line control and line status, plus the 16-bit baud divisor. The serial bit engine is a separate block. It takes bytes from the transmit FIFO with a pop strobe and delivers received bytes with a push strobe. It reads the divisor and line settings from dedicated outputs.

The divisor bytes have no addresses of their own. While the line control register's top bit is set, index 0 and index 1 reach the divisor low and high bytes. While that bit is clear, the same indexes reach the data path and the interrupt enable. A receive interrupt output requests service once the receive FIFO holds at least a programmable number of bytes. The host then drains the FIFO by reading the data register until the data-ready status bit drops.

An access lasts one clock cycle, during which `cs_n` and one strobe are low. Read data is combinational from the index and is valid during that cycle. Any side effect of an access (a pop or a flag clear) takes place at the clock edge that ends the cycle.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, the line status register (index 5) reads 0x20, the line control register (index 3) and the interrupt enable register (index 1) read 0x00, `rx_irq` and `tx_avail` are 0, `divisor` is 0 and `line_cfg` is 0.
- R2: While LCR bit 7 is 1, index 0 reads and writes the divisor low byte and index 1 the divisor high byte. Writes made there neither queue a transmit byte nor change the interrupt enable value. With LCR bit 7 at 0, index 0 is the data register and index 1 the interrupt enable register, which keeps bits 3:0 and reads its upper bits as 0.
- R3: A write to index 0 with LCR bit 7 clear queues the byte for transmission. The engine receives queued bytes on `tx_data` in write order and takes one per `tx_pop` cycle while `tx_avail` is 1. LSR bit 5 is 1 exactly when the transmit FIFO is empty.
- R4: Each `rx_push_valid` cycle queues `rx_push_data`. A read of index 0 with LCR bit 7 clear returns the oldest queued byte and removes it. LSR bit 0 is 1 exactly while at least one received byte waits.
- R5: With FCR bit 0 at 1, each FIFO holds up to 16 bytes. With FCR bit 0 at 0 (the reset state), each FIFO holds 1 byte. A byte offered to a full FIFO is discarded.
- R6: Writing FCR with bit 1 set empties the receive FIFO, and writing it with bit 2 set empties the transmit FIFO. Neither bit is stored. Any FCR write that changes bit 0 empties both FIFOs.
- R7: FCR bits 7:6 set the receive trigger level to 1, 4, 8 or 14 bytes for the codes 00, 01, 10 and 11. With FCR bit 0 at 0 the level is 1.
- R8: `rx_irq` is 1 exactly when IER bit 0 is 1 and the receive count is at or above the trigger level. It falls in the cycle after a read that brings the count below the level.
- R9: A receive push that meets a full receive FIFO sets LSR bit 1. A read of index 5 clears that bit, unless a new overrun occurs in the same cycle.
- R10: A read of the data register while the receive FIFO is empty returns the byte last removed from it (0 after reset) and changes no state.
- R11: `divisor` presents {high byte, low byte} and `line_cfg` presents LCR bits 6:0. Reads of indexes 2, 4, 6 and 7 return 0, and writes to indexes 4, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register index |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the selected index |
| rx_irq | output | 1 | Receive threshold interrupt request |
| rx_push_valid | input | 1 | Engine delivers a received byte this cycle |
| rx_push_data | input | 8 | Received byte |
| tx_pop | input | 1 | Engine takes the head transmit byte this cycle |
| tx_avail | output | 1 | Transmit FIFO holds at least one byte |
| tx_data | output | 8 | Head byte of the transmit FIFO |
| divisor | output | 16 | Baud divisor for the bit engine |
| line_cfg | output | 7 | Line control bits 6:0 for the bit engine |

## Verification
The data path is driven in three ways. Short runs of distinct bytes show that ordering is kept. Runs longer than 16 bytes separate a correct capacity from an off-by-one and show that overflowing bytes are discarded rather than overwriting stored ones. Single bytes with the FIFOs disabled show that the one-byte holding mode and its overrun flag work. The interrupt is swept through all four trigger codes with the count one below and exactly at each level, which tells a wrong level encoding apart from a wrong comparison. Divisor access, reads of an empty receive FIFO and accesses to unused indexes are each followed by reads of the registers and outputs those accesses might have disturbed.

// File: rtl/uhr_pkg.sv
// Package: uhr_pkg
// Shared constants for the UART host register block: the register index
// map, line status bit positions and the receive trigger-level decode.
// Assumes an 8-bit host bus and a 3-bit register index.
package uhr_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    // Register indexes; the host software depends on these values.
    localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;  // rx/tx data or divisor low
    localparam logic [IDX_W-1:0] IDX_IEN  = 3'd1;  // interrupt enable or divisor high
    localparam logic [IDX_W-1:0] IDX_FCTL = 3'd2;  // FIFO control, write only
    localparam logic [IDX_W-1:0] IDX_LCTL = 3'd3;  // line control
    localparam logic [IDX_W-1:0] IDX_LSTS = 5'd5;  // line status, read only

    // Line status bit positions.
    localparam int STS_READY   = 0;
    localparam int STS_OVERRUN = 1;
    localparam int STS_TXEMPTY = 5;

    // Map the two-bit trigger code to a byte count.
    function automatic int trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uhr_fifo.sv
// Module: uhr_fifo
// Circular byte queue with a run-time capacity limit. A push is taken only
// while the count is below `limit`; a pop only while the count is nonzero.
// `clr` empties the queue and overrides push and pop in that cycle.
// Assumes limit <= DEPTH. The head entry is presented combinationally.
module uhr_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [CW-1:0]    limit,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic             push_ok, pop_ok;

    assign push_ok = push && (count < limit);
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write; the array carries no reset.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R5: occupancy never exceeds the programmed capacity.
    a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);

    // R5: a push that meets a full queue leaves the count unchanged.
    a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count >= limit) |=> $stable(count));

    // R10: popping an empty queue keeps it empty.
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && count == '0) |=> (count == '0));

endmodule

// File: rtl/uhr_rx_trigger.sv
// Module: uhr_rx_trigger
// Receive interrupt decision. The level comes from the trigger code when
// the FIFOs are enabled and is one byte when they are not. The request is
// combinational from the count, so it follows every push and pop directly.
module uhr_rx_trigger #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic [1:0]    trig_code,
    input  logic          irq_en,
    input  logic [CW-1:0] rx_count,
    output logic          irq
);
    import uhr_pkg::*;

    int level;

    // Pick the active threshold for the current mode.
    always_comb begin
        level = fifo_on ? trig_bytes(trig_code) : 1;
    end

    // Raise the request at or above the threshold when enabled.
    always_comb begin
        irq = irq_en && (int'(rx_count) >= level);
    end

    // R7: in one-byte mode any waiting byte meets the threshold.
    a_r7_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && irq_en && rx_count != '0) |-> irq);

    // R8: no request while the receive side is empty.
    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !irq);

endmodule

// File: rtl/uart_host_regs.sv
// Module: uart_host_regs
// Host register file for one UART channel: bus decode, divisor latches
// behind the line-control access bit, FIFO control, line status with
// sticky overrun, and the receive threshold interrupt. Assumes one-cycle
// host accesses (cs_n plus one strobe low) and synchronous engine strobes.
module uart_host_regs #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        rx_irq,
    input  logic        rx_push_valid,
    input  logic [7:0]  rx_push_data,
    input  logic        tx_pop,
    output logic        tx_avail,
    output logic [7:0]  tx_data,
    output logic [15:0] divisor,
    output logic [6:0]  line_cfg
);
    import uhr_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_DEEP = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE  = CW'(1);

    logic [BYTE_W-1:0] lctl_q, dl_lo_q, dl_hi_q, last_rx_q;
    logic [3:0]        ien_q;
    logic              fifo_on_q, ovr_q;
    logic [1:0]        trig_q;

    logic              rd_acc, wr_acc, dlab;
    logic              data_wr, data_rd, sts_rd, fctl_wr, mode_flip;
    logic              rx_clr, tx_clr, rx_full, rx_pop_ok;
    logic [CW-1:0]     cap, rx_count, tx_count;
    logic [BYTE_W-1:0] rx_head, sts_val;

    // Bus access qualification and index decode.
    always_comb begin
        rd_acc    = !cs_n && !rd_n;
        wr_acc    = !cs_n && !wr_n;
        dlab      = lctl_q[7];
        data_wr   = wr_acc && (addr == IDX_DATA) && !dlab;
        data_rd   = rd_acc && (addr == IDX_DATA) && !dlab;
        sts_rd    = rd_acc && (addr == IDX_LSTS);
        fctl_wr   = wr_acc && (addr == IDX_FCTL);
        mode_flip = fctl_wr && (wdata[0] != fifo_on_q);
        rx_clr    = fctl_wr && (wdata[1] || mode_flip);
        tx_clr    = fctl_wr && (wdata[2] || mode_flip);
    end

    // Capacity and flow status derived from the FIFO mode.
    always_comb begin
        cap       = fifo_on_q ? CAP_DEEP : CAP_ONE;
        rx_full   = rx_count >= cap;
        rx_pop_ok = data_rd && (rx_count != '0);
    end

    uhr_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push_valid),
        .pop   (data_rd),
        .limit (cap),
        .din   (rx_push_data),
        .dout  (rx_head),
        .count (rx_count)
    );

    uhr_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (data_wr),
        .pop   (tx_pop),
        .limit (cap),
        .din   (wdata),
        .dout  (tx_data),
        .count (tx_count)
    );

    uhr_rx_trigger #(.CW(CW)) i_rx_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_on   (fifo_on_q),
        .trig_code (trig_q),
        .irq_en    (ien_q[0]),
        .rx_count  (rx_count),
        .irq       (rx_irq)
    );

    // Host-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lctl_q    <= '0;
            ien_q     <= '0;
            dl_lo_q   <= '0;
            dl_hi_q   <= '0;
            fifo_on_q <= 1'b0;
            trig_q    <= 2'b00;
        end else if (wr_acc) begin
            case (addr)
                IDX_DATA: if (dlab) dl_lo_q <= wdata;
                IDX_IEN:  if (dlab) dl_hi_q <= wdata; else ien_q <= wdata[3:0];
                IDX_FCTL: begin
                    fifo_on_q <= wdata[0];
                    trig_q    <= wdata[7:6];
                end
                IDX_LCTL: lctl_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Sticky overrun flag: set by a dropped push, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_push_valid && rx_full && !rx_clr) begin
            ovr_q <= 1'b1;
        end else if (sts_rd) begin
            ovr_q <= 1'b0;
        end
    end

    // Hold the last byte removed so empty reads repeat it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rx_q <= '0;
        end else if (rx_pop_ok) begin
            last_rx_q <= rx_head;
        end
    end

    // Line status composition.
    always_comb begin
        sts_val              = '0;
        sts_val[STS_READY]   = (rx_count != '0);
        sts_val[STS_OVERRUN] = ovr_q;
        sts_val[STS_TXEMPTY] = (tx_count == '0);
    end

    // Read-data multiplexer.
    always_comb begin
        case (addr)
            IDX_DATA: rdata = dlab ? dl_lo_q
                                   : ((rx_count != '0) ? rx_head : last_rx_q);
            IDX_IEN:  rdata = dlab ? dl_hi_q : {4'b0000, ien_q};
            IDX_LCTL: rdata = lctl_q;
            IDX_LSTS: rdata = sts_val;
            default:  rdata = '0;
        endcase
    end

    // Engine-facing outputs.
    always_comb begin
        tx_avail = (tx_count != '0);
        divisor  = {dl_hi_q, dl_lo_q};
        line_cfg = lctl_q[6:0];
    end

    // R9: a push that meets a full receive FIFO raises the overrun flag.
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_valid && rx_full && !rx_clr) |=> ovr_q);

    // R2: a divisor-low write never queues a transmit byte.
    a_r2_dlab_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && addr == IDX_DATA && dlab && !tx_pop) |=> $stable(tx_count));

    // R10: an empty data read keeps the repeated byte.
    a_r10_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_count == '0) |=> $stable(last_rx_q));

    // R8: a pending request implies received data is waiting.
    a_r8_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_count != '0));

    // R6: a receive-clear write leaves the receive FIFO empty.
    a_r6_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_count == '0));

endmodule

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rx_irq;
    logic        rx_push_valid = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        tx_pop = 1'b0;
    logic        tx_avail;
    logic [7:0]  tx_data;
    logic [15:0] divisor;
    logic [6:0]  line_cfg;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rx_irq(rx_irq),
        .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_data(tx_data),
        .divisor(divisor), .line_cfg(line_cfg)
    );

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic eng_push(input logic [7:0] d);
        @(negedge clk);
        rx_push_valid = 1'b1; rx_push_data = d;
        @(negedge clk);
        rx_push_valid = 1'b0;
    endtask

    task automatic eng_pop(output logic [7:0] d);
        @(negedge clk);
        d = tx_data; tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        host_rd(3'd5, v); check("R1 status", v, 8'h20);
        host_rd(3'd3, v); check("R1 line ctrl", v, 8'h00);
        host_rd(3'd1, v); check("R1 int enable", v, 8'h00);
        check("R1 irq", rx_irq, 0);
        check("R1 tx_avail", tx_avail, 0);
        check("R1 divisor", divisor, 0);
        check("R1 line_cfg", line_cfg, 0);
    endtask

    task automatic t_divisor();
        logic [7:0] v;
        host_wr(3'd3, 8'h80);
        host_wr(3'd0, 8'h08);
        host_wr(3'd1, 8'h01);
        host_rd(3'd0, v); check("R2 div low readback", v, 8'h08);
        host_rd(3'd1, v); check("R2 div high readback", v, 8'h01);
        check("R11 divisor out", divisor, 16'h0108);
        check("R2 no tx queued", tx_avail, 0);
        host_wr(3'd3, 8'h1b);
        host_rd(3'd1, v); check("R2 ien untouched", v, 8'h00);
        check("R11 line_cfg", line_cfg, 7'h1b);
        host_wr(3'd1, 8'hF1);
        host_rd(3'd1, v); check("R2 ien low nibble", v, 8'h01);
        check("R2 divisor kept", divisor, 16'h0108);
        host_wr(3'd1, 8'h00);
    endtask

    task automatic t_tx_fifo();
        logic [7:0] v;
        host_wr(3'd2, 8'h01);
        for (int i = 0; i < 18; i++) host_wr(3'd0, 8'hA0 + 8'(i));
        host_rd(3'd5, v); check("R3 status not empty", v & 8'h20, 0);
        for (int i = 0; i < 16; i++) begin
            eng_pop(v); check("R3 R5 tx order", v, 8'hA0 + i);
        end
        check("R5 extra bytes dropped", tx_avail, 0);
        host_rd(3'd5, v); check("R3 status empty", v, 8'h20);
    endtask

    task automatic t_rx_order();
        logic [7:0] v;
        eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
        host_rd(3'd5, v); check("R4 ready set", v, 8'h21);
        host_rd(3'd0, v); check("R4 rx first", v, 8'h11);
        host_rd(3'd0, v); check("R4 rx second", v, 8'h22);
        host_rd(3'd0, v); check("R4 rx third", v, 8'h33);
        host_rd(3'd5, v); check("R4 ready clear", v, 8'h20);
    endtask

    task automatic t_empty_read();
        logic [7:0] v;
        host_rd(3'd0, v); check("R10 repeat last", v, 8'h33);
        host_rd(3'd5, v); check("R10 status unchanged", v, 8'h20);
        eng_push(8'h44);
        host_rd(3'd0, v); check("R10 next byte intact", v, 8'h44);
    endtask

    task automatic t_trigger();
        logic [7:0] v;
        int lv;
        host_wr(3'd1, 8'h01);
        for (int s = 0; s < 4; s++) begin
            lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            host_wr(3'd2, 8'((s << 6) | 3));
            for (int k = 0; k < lv - 1; k++) eng_push(8'(k));
            check("R7 R8 below level", rx_irq, 0);
            eng_push(8'hEE);
            check("R7 R8 at level", rx_irq, 1);
            host_rd(3'd0, v);
            check("R8 falls below level", rx_irq, 0);
        end
        eng_push(8'h01);
        host_wr(3'd1, 8'h00);
        check("R8 disabled", rx_irq, 0);
        host_wr(3'd2, 8'h03);
    endtask

    task automatic t_fcr_reset();
        logic [7:0] v;
        for (int k = 0; k < 5; k++) eng_push(8'h50 + 8'(k));
        host_wr(3'd0, 8'hC1); host_wr(3'd0, 8'hC2);
        host_wr(3'd2, 8'h03);
        host_rd(3'd5, v); check("R6 rx cleared tx kept", v, 8'h00);
        host_wr(3'd2, 8'h05);
        host_rd(3'd5, v); check("R6 tx cleared", v, 8'h20);
        eng_push(8'h77);
        host_wr(3'd2, 8'h00);
        host_rd(3'd5, v); check("R6 mode change flushes", v, 8'h20);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        host_wr(3'd1, 8'h01);
        eng_push(8'h55);
        check("R7 single-byte level", rx_irq, 1);
        eng_push(8'h66);
        host_rd(3'd5, v); check("R5 R9 one-byte overrun", v, 8'h23);
        host_rd(3'd5, v); check("R9 cleared by read", v, 8'h21);
        host_rd(3'd0, v); check("R5 kept first byte", v, 8'h55);
        host_wr(3'd1, 8'h00);
        host_wr(3'd2, 8'h01);
        for (int k = 0; k < 17; k++) eng_push(8'(k));
        host_rd(3'd5, v); check("R9 deep overrun", v, 8'h23);
        for (int k = 0; k < 16; k++) begin
            host_rd(3'd0, v); check("R5 rx deep order", v, k);
        end
        host_rd(3'd5, v); check("R4 drained", v, 8'h20);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        host_wr(3'd7, 8'hFF); host_wr(3'd4, 8'hFF); host_wr(3'd6, 8'hFF);
        host_rd(3'd7, v); check("R11 idx7 reads zero", v, 0);
        host_rd(3'd2, v); check("R11 idx2 reads zero", v, 0);
        host_rd(3'd3, v); check("R11 line ctrl kept", v, 8'h1b);
        host_rd(3'd1, v); check("R11 ien kept", v, 0);
        host_rd(3'd5, v); check("R11 status kept", v, 8'h20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_tx_fifo();
        t_rx_order();
        t_empty_read();
        t_trigger();
        t_fcr_reset();
        t_overrun();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule